// File: doc/BRIEF.md
# Result Dispatch and Method Sender

This block sits behind the arithmetic stage of a small command processor and decides what happens to each finished result. A 3-bit mode code picks one of eight combinations of four actions: write the destination register, pop the next entry from a parameter queue, reload a method-address register, and emit a (method, data) write on an output with a valid/ready handshake. The mode code values and their meanings are fixed, because the stage before this one decodes them.

The method-address register holds a 12-bit address in bits 11:0 and a 6-bit step in bits 17:12. A reload copies bits 17:0 of the result into it. Every completed send carries the address that is in effect at that moment. Afterwards the address advances by the step and wraps modulo 4096. A command is taken in a single cycle. The exception is a sending mode when the output is not ready: the command then waits, and nothing it would do takes effect early.

Top module: `result_dispatch`

## Requirements
- R1: When a command is accepted (cmd_valid and cmd_ready) with cmd_dst not 0, rf_we is high in that cycle and rf_waddr equals cmd_dst. rf_wdata is the popped parameter for modes 0, 3 and 5, and cmd_result for modes 1, 2, 4, 6 and 7.
- R2: A command with cmd_dst equal to 0 never raises rf_we. Its fetch, reload and send still take place.
- R3: An accepted command in mode 0, 3, 5 or 6 pops exactly one queue entry (prm_pop high in that cycle). The other modes never pop.
- R4: Modes 2, 5, 6 and 7 load the method-address register from cmd_result: the address from bits 11:0 and the step from bits 17:12.
- R5: Modes 3, 4, 6 and 7 raise mw_valid. mw_addr is the address in effect after any reload made by the same command.
- R6: The send data is cmd_result in modes 3 and 4 and the popped parameter in mode 6. In mode 7 it is cmd_result bits 17:12, zero-extended.
- R7: After each accepted send, the address grows by the step modulo 4096. The step itself is unchanged.
- R8: While mw_valid is high and mw_ready is low, cmd_ready is low. In that state there is no register write, no pop and no change of the method-address register. Modes that do not send are accepted whatever mw_ready is.
- R9: A fetching mode that meets prm_empty does not pop and uses zero as the parameter. It sets err_underflow, which stays set until reset.
- R10: After reset the address and the step are both 0, and err_underflow is 0.
- R11: With cmd_valid low, rf_we, prm_pop and mw_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A result is offered |
| cmd_ready | output | 1 | The offered result is taken this cycle |
| cmd_op | input | 3 | Mode code 0 to 7 |
| cmd_dst | input | 3 | Destination register index |
| cmd_result | input | 32 | Result value |
| prm_empty | input | 1 | Parameter queue has no entry |
| prm_data | input | 32 | Head of the parameter queue |
| prm_pop | output | 1 | Remove the queue head |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mw_valid | output | 1 | Method write offered |
| mw_ready | input | 1 | Method write accepted |
| mw_addr | output | 12 | Method address |
| mw_data | output | 32 | Method data |
| err_underflow | output | 1 | Sticky parameter underflow flag |

## Verification
All eight modes are run with destination indices 0, 3 and 7. The output is held back in alternate sending runs and not in the others. The result values differ in bits 17:12, so a wrong data source, a wrong slice or a missing address advance gives a different value. A chain made only of reloads and sends crosses address 4095, which tests the wrap and shows that the step is kept. Fetches made after the queue is drained are given a non-zero value on the queue data lines. This tells the zero substitution apart from a stray pop.

// File: rtl/rd_pkg.sv
`timescale 1ns/1ps
package rd_pkg;
    localparam int DATA_W  = 32;
    localparam int REG_N   = 8;
    localparam int MADDR_W = 12;
    localparam int MINC_W  = 6;
    localparam int MAR_W   = MADDR_W + MINC_W;

    typedef enum logic [2:0] {
        OP_FETCH_DROP   = 3'd0,
        OP_MOVE         = 3'd1,
        OP_MOVE_LOAD    = 3'd2,
        OP_FETCH_SEND   = 3'd3,
        OP_MOVE_SEND    = 3'd4,
        OP_FETCH_LOAD   = 3'd5,
        OP_LOAD_PSEND   = 3'd6,
        OP_LOAD_SLICE   = 3'd7
    } rd_op_e;

    typedef enum logic [1:0] {
        SD_RESULT = 2'd0,
        SD_PARAM  = 2'd1,
        SD_SLICE  = 2'd2
    } rd_sdsel_e;

    typedef struct packed {
        logic      fetch;
        logic      reg_param;
        logic      load;
        logic      send;
        rd_sdsel_e sdsel;
    } rd_ctl_t;

    function automatic rd_ctl_t rd_decode_fn(rd_op_e op);
        rd_ctl_t c;
        c = '{fetch: 1'b0, reg_param: 1'b0, load: 1'b0, send: 1'b0, sdsel: SD_RESULT};
        case (op)
            OP_FETCH_DROP: begin c.fetch = 1'b1; c.reg_param = 1'b1; end
            OP_MOVE:       ;
            OP_MOVE_LOAD:  c.load = 1'b1;
            OP_FETCH_SEND: begin c.fetch = 1'b1; c.reg_param = 1'b1; c.send = 1'b1; end
            OP_MOVE_SEND:  c.send = 1'b1;
            OP_FETCH_LOAD: begin c.fetch = 1'b1; c.reg_param = 1'b1; c.load = 1'b1; end
            OP_LOAD_PSEND: begin c.fetch = 1'b1; c.load = 1'b1; c.send = 1'b1; c.sdsel = SD_PARAM; end
            OP_LOAD_SLICE: begin c.load = 1'b1; c.send = 1'b1; c.sdsel = SD_SLICE; end
            default:       ;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/rd_decode.sv
`timescale 1ns/1ps
module rd_decode
    import rd_pkg::*;
(
    input  rd_op_e  op,
    output rd_ctl_t ctl
);
    always_comb ctl = rd_decode_fn(op);
endmodule

// File: rtl/rd_param_port.sv
`timescale 1ns/1ps
module rd_param_port #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          want,
    input  logic          prm_empty,
    input  logic [DW-1:0] prm_data,
    output logic          prm_pop,
    output logic [DW-1:0] fetched,
    output logic          err
);
    logic err_q;

    assign prm_pop = want && !prm_empty;
    assign fetched = prm_empty ? '0 : prm_data;
    assign err     = err_q;

    always_ff @(posedge clk) begin
        if (rst)                     err_q <= 1'b0;
        else if (want && prm_empty)  err_q <= 1'b1;
    end

    // R9
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        prm_pop |-> !prm_empty);
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
endmodule

// File: rtl/rd_method_reg.sv
`timescale 1ns/1ps
module rd_method_reg #(
    parameter int AW = 12,
    parameter int IW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           commit,
    input  logic           load,
    input  logic           send,
    input  logic [AW+IW-1:0] load_val,
    output logic [AW-1:0]  send_addr
);
    logic [AW-1:0] addr_q, base_addr, next_addr;
    logic [IW-1:0] inc_q, base_inc;

    always_comb begin
        base_addr = load ? load_val[AW-1:0] : addr_q;
        base_inc  = load ? load_val[AW +: IW] : inc_q;
        next_addr = send ? base_addr + AW'(base_inc) : base_addr;
    end

    assign send_addr = base_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            inc_q  <= '0;
        end else if (commit) begin
            addr_q <= next_addr;
            inc_q  <= base_inc;
        end
    end

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        commit && send && !load |=> addr_q == AW'($past(addr_q) + AW'($past(inc_q))));
    // R7
    inc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        commit && !load |=> inc_q == $past(inc_q));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(addr_q) && $stable(inc_q));
endmodule

// File: rtl/result_dispatch.sv
`timescale 1ns/1ps
module result_dispatch
    import rd_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int NREG = REG_N,
    parameter int AW   = MADDR_W,
    parameter int IW   = MINC_W,
    localparam int RA_W = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [2:0]      cmd_op,
    input  logic [RA_W-1:0] cmd_dst,
    input  logic [DW-1:0]   cmd_result,
    input  logic            prm_empty,
    input  logic [DW-1:0]   prm_data,
    output logic            prm_pop,
    output logic            rf_we,
    output logic [RA_W-1:0] rf_waddr,
    output logic [DW-1:0]   rf_wdata,
    output logic            mw_valid,
    input  logic            mw_ready,
    output logic [AW-1:0]   mw_addr,
    output logic [DW-1:0]   mw_data,
    output logic            err_underflow
);
    rd_ctl_t        ctl;
    logic           fire;
    logic [DW-1:0]  fetched;
    logic [DW-1:0]  slice_val;

    rd_decode u_dec (
        .op  (rd_op_e'(cmd_op)),
        .ctl (ctl)
    );

    assign cmd_ready = !ctl.send || mw_ready;
    assign fire      = cmd_valid && cmd_ready;

    rd_param_port #(.DW(DW)) u_prm (
        .clk       (clk),
        .rst       (rst),
        .want      (fire && ctl.fetch),
        .prm_empty (prm_empty),
        .prm_data  (prm_data),
        .prm_pop   (prm_pop),
        .fetched   (fetched),
        .err       (err_underflow)
    );

    rd_method_reg #(.AW(AW), .IW(IW)) u_mar (
        .clk       (clk),
        .rst       (rst),
        .commit    (fire),
        .load      (ctl.load),
        .send      (ctl.send),
        .load_val  (cmd_result[AW+IW-1:0]),
        .send_addr (mw_addr)
    );

    assign slice_val = {{(DW-IW){1'b0}}, cmd_result[AW +: IW]};

    always_comb begin
        case (ctl.sdsel)
            SD_PARAM: mw_data = fetched;
            SD_SLICE: mw_data = slice_val;
            default:  mw_data = cmd_result;
        endcase
    end

    assign mw_valid = cmd_valid && ctl.send;
    assign rf_we    = fire && (cmd_dst != '0);
    assign rf_waddr = cmd_dst;
    assign rf_wdata = ctl.reg_param ? fetched : cmd_result;

    // R2
    no_r0_write_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> rf_waddr != '0);
    // R8
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mw_valid && !mw_ready |-> !cmd_ready && !rf_we && !prm_pop);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> !rf_we && !prm_pop && !mw_valid);
    // R6
    slice_width_chk: assert property (@(posedge clk) disable iff (rst)
        mw_valid && cmd_op == 3'd7 |-> mw_data[DW-1:IW] == '0);
endmodule

// File: tb/result_dispatch_tb_top.sv
`timescale 1ns/1ps
module result_dispatch_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_ready;
    logic [2:0]  cmd_op, cmd_dst;
    logic [31:0] cmd_result;
    logic        prm_empty, prm_pop;
    logic [31:0] prm_data;
    logic        rf_we;
    logic [2:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        mw_valid, mw_ready;
    logic [11:0] mw_addr;
    logic [31:0] mw_data;
    logic        err_underflow;

    always #10 clk = ~clk;

    result_dispatch dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_result(cmd_result),
        .prm_empty(prm_empty), .prm_data(prm_data), .prm_pop(prm_pop),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
        .mw_data(mw_data), .err_underflow(err_underflow)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] q [0:11];
    int qn = 12;
    int qi = 0;
    logic [11:0] m_addr;
    logic [5:0]  m_inc;
    logic        m_err;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input int op, input logic [2:0] dst, input logic [31:0] res,
                           input bit stall, input string note);
        bit fetch, rparam, load, send, empty;
        logic [31:0] pv, sdata;
        logic [11:0] ba;
        logic [5:0]  bi;
        fetch  = (op == 0 || op == 3 || op == 5 || op == 6);
        rparam = (op == 0 || op == 3 || op == 5);
        load   = (op == 2 || op == 5 || op == 6 || op == 7);
        send   = (op == 3 || op == 4 || op == 6 || op == 7);
        empty  = (qi >= qn);
        pv     = empty ? 32'h0 : q[qi];
        ba     = load ? res[11:0]  : m_addr;
        bi     = load ? res[17:12] : m_inc;
        sdata  = (op == 6) ? pv : (op == 7) ? {26'h0, res[17:12]} : res;

        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_op     = op[2:0];
        cmd_dst    = dst;
        cmd_result = res;
        prm_empty  = empty;
        prm_data   = empty ? 32'hDEAD_BEEF : q[qi];
        mw_ready   = !stall;
        if (stall && send) begin
            #2;
            chk({"R8 stall ready ", note}, {31'h0, cmd_ready}, 32'h0);
            chk({"R8 stall we ", note},    {31'h0, rf_we},     32'h0);
            chk({"R8 stall pop ", note},   {31'h0, prm_pop},   32'h0);
            chk({"R8 stall valid ", note}, {31'h0, mw_valid},  32'h1);
            @(negedge clk);
            mw_ready = 1'b1;
        end
        #2;
        chk({"R8 ready ", note}, {31'h0, cmd_ready}, 32'h1);
        chk({"R1 R2 we ", note}, {31'h0, rf_we}, {31'h0, dst != 3'd0});
        if (dst != 3'd0) begin
            chk({"R1 waddr ", note}, {29'h0, rf_waddr}, {29'h0, dst});
            chk({"R1 wdata ", note}, rf_wdata, rparam ? pv : res);
        end
        chk({"R3 pop ", note}, {31'h0, prm_pop}, {31'h0, fetch && !empty});
        chk({"R5 valid ", note}, {31'h0, mw_valid}, {31'h0, send});
        if (send) begin
            chk({"R4 R5 addr ", note}, {20'h0, mw_addr}, {20'h0, ba});
            chk({"R6 data ", note}, mw_data, sdata);
        end
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        if (fetch && !empty) qi++;
        if (fetch && empty)  m_err = 1'b1;
        m_addr = send ? ba + {6'h0, bi} : ba;
        m_inc  = bi;
        #1;
        chk({"R9 err ", note}, {31'h0, err_underflow}, {31'h0, m_err});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 12; i++) q[i] = 32'hC000_0000 + 32'(i) * 32'h0101_0011;
        m_addr = '0; m_inc = '0; m_err = 1'b0;
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_dst = '0; cmd_result = '0;
        prm_empty = 1'b0; prm_data = q[0]; mw_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R10 and R11 after reset with nothing offered
        chk("R10 err after reset", {31'h0, err_underflow}, 32'h0);
        chk("R11 idle we",    {31'h0, rf_we},    32'h0);
        chk("R11 idle pop",   {31'h0, prm_pop},  32'h0);
        chk("R11 idle valid", {31'h0, mw_valid}, 32'h0);
        // R10: first send without a reload uses address 0 and step 0
        run_cmd(4, 3'd1, 32'h0000_ABCD, 1'b0, "R10 first send");
        run_cmd(4, 3'd1, 32'h0000_1234, 1'b0, "R10 zero step");
        // sweep of all modes and destinations
        for (int o = 0; o < 8; o++) begin
            for (int d = 0; d < 3; d++) begin
                logic [2:0]  dst;
                logic [31:0] res;
                dst = (d == 0) ? 3'd0 : (d == 1) ? 3'd3 : 3'd7;
                res = 32'h1234_5678 ^ (32'(o) * 32'h0107_3F11) ^ (32'(d) * 32'h0002_9E37);
                run_cmd(o, dst, res, ((o + d) % 2) == 1, $sformatf("sweep op%0d dst%0d", o, dst));
            end
        end
        // R7 wrap across 4095 with step 63
        run_cmd(2, 3'd2, 32'h0003_FFF0, 1'b0, "R7 load");
        run_cmd(4, 3'd2, 32'h0000_0001, 1'b1, "R7 pre-wrap");
        run_cmd(4, 3'd2, 32'h0000_0002, 1'b0, "R7 post-wrap");
        run_cmd(1, 3'd4, 32'h0000_0003, 1'b1, "R7 R8 non-send");
        run_cmd(4, 3'd4, 32'h0000_0004, 1'b0, "R7 step kept");
        // R9 underflow: queue is drained by now
        while (qi < qn) run_cmd(0, 3'd5, 32'h0, 1'b0, "drain");
        run_cmd(3, 3'd5, 32'h0000_7777, 1'b0, "R9 underflow send");
        run_cmd(6, 3'd6, 32'h0002_1100, 1'b1, "R9 underflow param send");
        run_cmd(1, 3'd6, 32'h0000_0055, 1'b0, "R9 sticky");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule